// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a memory-mapped SPI master that runs one whole flash-style command each time software triggers it. Software loads the bytes to send into a shared byte FIFO, writes an 8-bit opcode, sets transmit and receive byte counts, picks one of four chip-select lines, then sets an execute bit. The engine sends the opcode, then the transmit bytes taken from the FIFO, then clocks in the requested number of response bytes. The response bytes go into the same FIFO, directly after the transmitted ones. Software polls a busy flag until it falls and then reads the response out of the FIFO.

The host port is a byte-wide synchronous register interface. Read data appears one cycle after the read strobe. The serial side uses SPI mode 0 with the MSB first. The serial clock is the system clock divided by the even parameter `CLK_DIV`, so half an SCLK period is `CLK_DIV/2` system cycles.

The sequencer is a state machine with five states:

- IDLE waits for the execute bit. On execute it goes to LEAD.
- LEAD holds the chip select low for half a period. Its tick goes to HIGH.
- HIGH is the SCLK-high phase. At its tick it goes to TRAIL if the last bit of the last byte has just been shifted, and to LOW otherwise.
- LOW is the SCLK-low phase. Its tick goes to HIGH.
- TRAIL holds the chip select low for half a period after the final falling edge. Its tick goes to IDLE.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the following hold: busy reads 0, every chip select is high, SCLK and MOSI are low, all configuration registers read 0 and the FIFO reads 0.
- R2: The register map is byte-addressed, and written values read back one cycle after the read strobe.
  - Opcode register: 0x00.
  - Control byte: 0x02. Bit 0 is execute and bit 4 is the pointer clear, so they sit at bits 16 and 20 of the 32-bit control word.
  - Busy flag: bit 7 of 0x03, which is bit 31 of the control word.
  - Chip select: bits [1:0] of 0x1D.
  - Transmit count: 0x48.
  - Receive count: 0x4B.
  - Status: 0x4C, with busy in bit 0.
  - FIFO entry i: 0x80+i, for i from 0 to 69.
- R3: Writing 1 to the execute bit while idle starts a command. Busy reads 1 from the next cycle and returns to 0 when the command completes.
- R4: MOSI carries the following, in order and MSB first:
  1. the opcode;
  2. the transmit-count FIFO bytes, starting at the FIFO pointer;
  3. one all-zero byte per receive byte.
- R5: Received bytes are written into the FIFO at indices starting at pointer plus the transmit count, so after a pointer clear they sit at 0x80+txcount+i.
- R6: The serial side runs in mode 0.
  - SCLK idles low.
  - MISO is sampled on the rising edge and MOSI changes only while SCLK is low.
  - Each SCLK level lasts CLK_DIV/2 cycles.
  - A command gives exactly 8×(1+tx+rx) rising edges, using the clamped counts.
- R7: Only the selected chip select goes low.
  - It falls CLK_DIV/2 cycles before the first rising edge.
  - It stays low for the whole command.
  - It rises CLK_DIV/2 cycles after the last falling edge.
- R8: A write of 1 to the pointer-clear bit resets the FIFO pointer to 0. Without a clear, the next command starts where the previous one ended, with the pointer wrapping modulo 70.
- R9: While busy, every register write is ignored, including execute and pointer clear.
- R10: A receive count of 0 ends the command after the transmit phase. With both counts at 0, only the opcode is sent.
- R11: A transmit count above 70 is clamped to 70. The receive count is clamped to 70 minus the clamped transmit count.
- R12: The execute and clear bits self-clear, and byte 0x02 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A wrong FIFO pointer, or a count that was not clamped, shows within the first transmitted data byte. It appears as a wrong MOSI byte, or as response data read back from the wrong FIFO address once busy falls. A sequencer that leaves a state early or late shows within one half period: the chip-select lead or trail time changes, or the total number of SCLK rising edges changes. A missing busy guard shows after the command, as a configuration register holding a value written mid-command, or as a second burst of SCLK edges.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } eng_state_t;

    localparam logic [7:0] ADDR_OPC  = 8'h00;
    localparam logic [7:0] ADDR_CTL  = 8'h02;
    localparam logic [7:0] ADDR_FLG  = 8'h03;
    localparam logic [7:0] ADDR_CSEL = 8'h1D;
    localparam logic [7:0] ADDR_TXN  = 8'h48;
    localparam logic [7:0] ADDR_RXN  = 8'h4B;
    localparam logic [7:0] ADDR_STAT = 8'h4C;
    localparam logic [7:0] ADDR_FIFO = 8'h80;

    localparam int CTL_GO_BIT   = 0;
    localparam int CTL_CLR_BIT  = 4;
    localparam int FLG_BUSY_BIT = 7;

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [TW-1:0] LAST = TW'(HALF - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_idle_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int DEPTH = 70
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic [$clog2(DEPTH)-1:0] host_idx,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    input  logic                     eng_we,
    input  logic [$clog2(DEPTH)-1:0] eng_idx,
    input  logic [7:0]               eng_wdata,
    output logic [7:0]               eng_rdata
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g] <= 8'h00;
                end else if (eng_we && eng_idx == PTR_W'(g)) begin
                    mem[g] <= eng_wdata;
                end else if (host_we && host_idx == PTR_W'(g)) begin
                    mem[g] <= host_wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        host_rdata = (int'(host_idx) < DEPTH) ? mem[host_idx] : 8'h00;
        eng_rdata  = (int'(eng_idx) < DEPTH) ? mem[eng_idx] : 8'h00;
    end

    p_single_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && eng_we));
    p_eng_idx_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (int'(eng_idx) < DEPTH));
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH  = 70,
    parameter int NUM_CS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [7:0]                reg_addr,
    input  logic [7:0]                reg_wdata,
    output logic [7:0]                reg_rdata,
    input  logic                      busy,
    input  logic [7:0]                fifo_rdata,
    output logic [$clog2(DEPTH)-1:0]  fifo_idx,
    output logic                      fifo_we,
    output logic [7:0]                fifo_wdata,
    output logic [7:0]                opcode,
    output logic [((NUM_CS > 1) ? $clog2(NUM_CS) : 1)-1:0] cs_sel,
    output logic [7:0]                tx_cnt,
    output logic [7:0]                rx_cnt,
    output logic                      go,
    output logic                      clr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    logic       wr_ok;
    logic [7:0] fifo_off;
    logic       fifo_hit;
    logic [7:0] rd_mux;

    assign wr_ok    = reg_wr && !busy;
    assign fifo_off = reg_addr - ADDR_FIFO;
    assign fifo_hit = (reg_addr >= ADDR_FIFO) && (fifo_off < DEPTH_B);

    assign fifo_idx   = fifo_off[PTR_W-1:0];
    assign fifo_we    = wr_ok && fifo_hit;
    assign fifo_wdata = reg_wdata;

    assign go  = wr_ok && (reg_addr == ADDR_CTL) && reg_wdata[CTL_GO_BIT];
    assign clr = wr_ok && (reg_addr == ADDR_CTL) && reg_wdata[CTL_CLR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= 8'h00;
            cs_sel <= '0;
            tx_cnt <= 8'h00;
            rx_cnt <= 8'h00;
        end else if (wr_ok) begin
            unique case (reg_addr)
                ADDR_OPC:  opcode <= reg_wdata;
                ADDR_CSEL: cs_sel <= reg_wdata[CS_W-1:0];
                ADDR_TXN:  tx_cnt <= reg_wdata;
                ADDR_RXN:  rx_cnt <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = 8'h00;
        if (fifo_hit) begin
            rd_mux = fifo_rdata;
        end else begin
            unique case (reg_addr)
                ADDR_OPC:  rd_mux = opcode;
                ADDR_FLG:  rd_mux[FLG_BUSY_BIT] = busy;
                ADDR_CSEL: rd_mux[CS_W-1:0] = cs_sel;
                ADDR_TXN:  rd_mux = tx_cnt;
                ADDR_RXN:  rd_mux = rx_cnt;
                ADDR_STAT: rd_mux[0] = busy;
                default:   rd_mux = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= 8'h00;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> ($stable(opcode) && $stable(tx_cnt) &&
                              $stable(rx_cnt) && $stable(cs_sel)));
    p_no_go_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(go || clr || fifo_we));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH  = 70,
    parameter int NUM_CS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic                      clr,
    input  logic [7:0]                opcode,
    input  logic [((NUM_CS > 1) ? $clog2(NUM_CS) : 1)-1:0] cs_sel,
    input  logic [7:0]                tx_cnt,
    input  logic [7:0]                rx_cnt,
    input  logic                      tick,
    input  logic                      miso,
    input  logic [7:0]                fifo_rdata,
    output logic [$clog2(DEPTH)-1:0]  fifo_idx,
    output logic                      fifo_we,
    output logic [7:0]                fifo_wdata,
    output logic                      run,
    output logic                      busy,
    output logic                      sclk,
    output logic                      mosi,
    output logic [NUM_CS-1:0]         cs_n
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam logic [8:0] DEPTH_W = 9'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    eng_state_t state, state_n;

    logic [7:0]       sh;
    logic [7:0]       rx_sh;
    logic [2:0]       bit_cnt;
    logic [PTR_W-1:0] ptr;
    logic [8:0]       tx_left;
    logic [8:0]       rx_left;
    logic             in_rx;
    logic [CS_W-1:0]  cs_lat;

    logic [8:0] tx_clamp;
    logic [8:0] room;
    logic [8:0] rx_clamp;
    logic       last_bit;
    logic       more_tx;
    logic       more_rx;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        tx_clamp = ({1'b0, tx_cnt} > DEPTH_W) ? DEPTH_W : {1'b0, tx_cnt};
        room     = DEPTH_W - tx_clamp;
        rx_clamp = ({1'b0, rx_cnt} > room) ? room : {1'b0, rx_cnt};
    end

    assign last_bit = (bit_cnt == 3'd7);
    assign more_tx  = (tx_left != 9'd0);
    assign more_rx  = (rx_left != 9'd0);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (go)   state_n = ST_LEAD;
            ST_LEAD:  if (tick) state_n = ST_HIGH;
            ST_HIGH:  if (tick) state_n = (last_bit && !more_tx && !more_rx)
                                          ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick) state_n = ST_HIGH;
            ST_TRAIL: if (tick) state_n = ST_IDLE;
            default:            state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath: shifter, counters, FIFO pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= 8'h00;
            rx_sh   <= 8'h00;
            bit_cnt <= 3'd0;
            ptr     <= '0;
            tx_left <= 9'd0;
            rx_left <= 9'd0;
            in_rx   <= 1'b0;
            cs_lat  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (clr) ptr <= '0;
                    if (go) begin
                        sh      <= opcode;
                        rx_sh   <= 8'h00;
                        bit_cnt <= 3'd0;
                        tx_left <= tx_clamp;
                        rx_left <= rx_clamp;
                        in_rx   <= 1'b0;
                        cs_lat  <= cs_sel;
                    end
                end
                ST_LEAD, ST_LOW: begin
                    if (tick) rx_sh <= {rx_sh[6:0], miso};
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (!last_bit) begin
                            sh      <= {sh[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 3'd1;
                        end else begin
                            bit_cnt <= 3'd0;
                            if (in_rx || more_tx) ptr <= ptr_next(ptr);
                            if (more_tx) begin
                                sh      <= fifo_rdata;
                                tx_left <= tx_left - 9'd1;
                                in_rx   <= 1'b0;
                            end else if (more_rx) begin
                                sh      <= 8'h00;
                                rx_left <= rx_left - 9'd1;
                                in_rx   <= 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign fifo_idx   = ptr;
    assign fifo_we    = (state == ST_HIGH) && tick && last_bit && in_rx;
    assign fifo_wdata = rx_sh;

    // outputs
    always_comb begin
        busy = (state != ST_IDLE);
        run  = busy;
        sclk = (state == ST_HIGH);
        mosi = (state == ST_LEAD || state == ST_HIGH || state == ST_LOW) ? sh[7] : 1'b0;
    end

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
            assign cs_n[g] = !(busy && cs_lat == CS_W'(g));
        end
    endgenerate

    p_one_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(~cs_n) == 1));
    p_cs_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
    p_go_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);
    p_ptr_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < DEPTH);
    p_left_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (10'(tx_left) + 10'(rx_left)) <= 10'(DEPTH));
    p_rx_after_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_rx |-> !more_tx);
    p_rx_zero_mosi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rx && (state == ST_HIGH || state == ST_LOW)) |-> !mosi);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
    parameter int DEPTH   = 70,
    parameter int NUM_CS  = 4,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam int HALF  = CLK_DIV / 2;

    logic             busy, run, tick, go, clr;
    logic [7:0]       opcode, tx_cnt, rx_cnt;
    logic [CS_W-1:0]  cs_sel;
    logic [PTR_W-1:0] h_idx, e_idx;
    logic             h_we, e_we;
    logic [7:0]       h_wdata, h_rdata, e_wdata, e_rdata;

    spi_cmd_regs #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .fifo_rdata(h_rdata), .fifo_idx(h_idx),
        .fifo_we(h_we), .fifo_wdata(h_wdata),
        .opcode(opcode), .cs_sel(cs_sel), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .go(go), .clr(clr)
    );

    spi_cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .host_we(h_we), .host_idx(h_idx), .host_wdata(h_wdata), .host_rdata(h_rdata),
        .eng_we(e_we), .eng_idx(e_idx), .eng_wdata(e_wdata), .eng_rdata(e_rdata)
    );

    spi_cmd_tick #(.HALF(HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    spi_cmd_seq #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .clr(clr),
        .opcode(opcode), .cs_sel(cs_sel), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tick(tick), .miso(spi_miso), .fifo_rdata(e_rdata),
        .fifo_idx(e_idx), .fifo_we(e_we), .fifo_wdata(e_wdata),
        .run(run), .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
    );
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 4;
    localparam int HALF  = DIV / 2;
    localparam int DEPTH = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sclk, mosi;
    logic       miso;
    logic [3:0] cs_n;
    logic       cs_idle;

    assign cs_idle = &cs_n;

    spi_cmd_engine #(.DEPTH(DEPTH), .NUM_CS(4), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [7:0] slv_bytes [80];
    logic [7:0] cap [80];
    logic [7:0] mdl [DEPTH];
    int mptr = 0;
    int rise_cnt = 0;
    int cyc = 0;
    int cs_fall_cyc = 0, first_rise_cyc = 0, last_fall_cyc = 0, cs_rise_cyc = 0;
    logic [3:0] cs_seen = 4'h0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle counter and serial slave model
    initial forever begin @(posedge clk); cyc++; end
    initial forever begin
        @(posedge sclk);
        if (rise_cnt == 0) first_rise_cyc = cyc;
        if (rise_cnt < 640) cap[rise_cnt / 8] = {cap[rise_cnt / 8][6:0], mosi};
        rise_cnt++;
    end
    initial begin
        miso = 1'b0;
        forever begin
            @(negedge sclk or negedge cs_idle);
            miso = slv_bytes[(rise_cnt / 8) % 80][7 - (rise_cnt % 8)];
        end
    end
    initial forever begin @(negedge cs_idle); cs_fall_cyc = cyc; cs_seen = ~cs_n; end
    initial forever begin @(posedge cs_idle); cs_rise_cyc = cyc; end
    initial forever begin @(negedge sclk); last_fall_cyc = cyc; end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic run_cmd(input logic [7:0] op, input int csel, input int tx,
                           input int rx, input bit clr, input bit meddle);
        int txc, rxc, ps, tmo, idx, rises;
        logic [7:0] d;
        txc = (tx > DEPTH) ? DEPTH : tx;
        rxc = (rx > DEPTH - txc) ? DEPTH - txc : rx;
        ps  = clr ? 0 : mptr;
        for (int i = 0; i < txc; i++) begin
            idx = (ps + i) % DEPTH;
            d = 8'($urandom);
            mdl[idx] = d;
            wr(8'(8'h80 + idx), d);
        end
        wr(8'h00, op);
        wr(8'h1D, 8'(csel));
        wr(8'h48, 8'(tx));
        wr(8'h4B, 8'(rx));
        for (int i = 0; i < 80; i++) begin
            slv_bytes[i] = 8'($urandom);
            cap[i] = 8'h00;
        end
        rise_cnt = 0;
        wr(8'h02, clr ? 8'h11 : 8'h01);
        rd(8'h03, d);
        check("R3", "busy after execute", 32'(d[7]), 32'd1);
        if (meddle) begin
            wr(8'h00, ~op);
            wr(8'h1D, 8'(csel ^ 1));
            wr(8'h48, 8'h33);
            wr(8'h02, 8'h11);
        end
        tmo = 0;
        do begin
            rd(8'h03, d);
            tmo++;
        end while (d[7] && tmo < 5000);
        check("R3", "busy cleared at end", 32'(d[7]), 32'd0);
        check("R6", "rising edge count", 32'(rise_cnt), 32'(8 * (1 + txc + rxc)));
        check("R4", "opcode on MOSI", 32'(cap[0]), 32'(op));
        for (int i = 0; i < txc; i++)
            check("R4", "tx byte on MOSI", 32'(cap[1 + i]), 32'(mdl[(ps + i) % DEPTH]));
        for (int j = 0; j < rxc; j++)
            check("R4", "zero MOSI in rx phase", 32'(cap[1 + txc + j]), 32'd0);
        check("R7", "chip select used", 32'(cs_seen), 32'(4'b0001 << csel));
        check("R7", "lead time", 32'(first_rise_cyc - cs_fall_cyc), 32'(HALF));
        check("R7", "trail time", 32'(cs_rise_cyc - last_fall_cyc), 32'(HALF));
        for (int j = 0; j < rxc; j++) begin
            idx = (ps + txc + j) % DEPTH;
            mdl[idx] = slv_bytes[1 + txc + j];
            rd(8'(8'h80 + idx), d);
            check("R5", "rx byte in FIFO", 32'(d), 32'(mdl[idx]));
        end
        mptr = (ps + txc + rxc) % DEPTH;
        rd(8'h02, d);
        check("R12", "control byte self-cleared", 32'(d), 32'd0);
        if (meddle) begin
            rises = rise_cnt;
            rd(8'h00, d);
            check("R9", "opcode kept", 32'(d), 32'(op));
            rd(8'h48, d);
            check("R9", "tx count kept", 32'(d), 32'(8'(tx)));
            rd(8'h1D, d);
            check("R9", "chip select kept", 32'(d), 32'(csel));
            repeat (40) @(negedge clk);
            check("R9", "no second command", 32'(rise_cnt), 32'(rises));
            check("R9", "chip selects idle", 32'(cs_n), 32'hF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h1234_5EED));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        for (int i = 0; i < 80; i++) slv_bytes[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "chip selects high", 32'(cs_n), 32'hF);
        check("R1", "sclk low", 32'(sclk), 32'd0);
        check("R1", "mosi low", 32'(mosi), 32'd0);
        rd(8'h03, d); check("R1", "busy low", 32'(d), 32'd0);
        rd(8'h4B, d); check("R1", "rx count zero", 32'(d), 32'd0);
        rd(8'h00, d); check("R1", "opcode zero", 32'(d), 32'd0);
        rd(8'h85, d); check("R1", "fifo zero", 32'(d), 32'd0);

        // R2 register map readback
        wr(8'h00, 8'h9F); rd(8'h00, d); check("R2", "opcode readback", 32'(d), 32'h9F);
        wr(8'h1D, 8'h02); rd(8'h1D, d); check("R2", "cs readback", 32'(d), 32'h02);
        wr(8'h48, 8'h05); rd(8'h48, d); check("R2", "tx count readback", 32'(d), 32'h05);
        wr(8'h4B, 8'h07); rd(8'h4B, d); check("R2", "rx count readback", 32'(d), 32'h07);
        wr(8'hC5, 8'h3C); rd(8'hC5, d); check("R2", "last fifo entry", 32'(d), 32'h3C);
        mdl[69] = 8'h3C;
        rd(8'h4C, d); check("R2", "status idle", 32'(d), 32'd0);

        // basic command
        run_cmd(8'h03, 0, 4, 6, 1'b1, 1'b0);
        // R10 receive count zero, and opcode only
        run_cmd(8'h06, 3, 2, 0, 1'b1, 1'b0);
        run_cmd(8'hB9, 1, 0, 0, 1'b1, 1'b0);
        // R8 pointer continues without clear
        run_cmd(8'h0B, 1, 3, 2, 1'b1, 1'b0);
        run_cmd(8'h0C, 2, 2, 3, 1'b0, 1'b0);
        // R9 writes while busy are ignored
        run_cmd(8'h9E, 3, 0, 10, 1'b1, 1'b1);
        // R11 clamping
        run_cmd(8'h02, 0, 75, 5, 1'b1, 1'b0);
        run_cmd(8'h5A, 1, 60, 20, 1'b1, 1'b0);
        // R8 wrap of pointer modulo depth
        run_cmd(8'h77, 2, 60, 5, 1'b1, 1'b0);
        run_cmd(8'h78, 3, 4, 4, 1'b0, 1'b0);

        // constrained random commands
        for (int k = 0; k < 16; k++) begin
            run_cmd(8'($urandom), int'($urandom % 4), int'($urandom % 9),
                    int'($urandom % 9), ($urandom % 4) != 0, 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule